// File: doc/BRIEF.md
# BCD time-of-day counter

This block holds the wall-clock time of day as three packed BCD fields (hours, minutes, seconds) in one 22-bit word. A single-cycle strobe, produced elsewhere once per second, moves the time forward by one second, with the usual carries from seconds into minutes, from minutes into hours, and from 23:59:59 back to midnight.

Software can load the fields through an already-decoded, already-registered write port. A three-bit lane mask picks which fields the write may touch. Each selected field is range-checked on its own. A field whose digits are not legal BCD for its range is dropped, and the other fields of the same write still land. A registered end-of-day flag is high for the whole final second of the day. A calendar stage downstream can AND it with the second strobe to find the last clock cycle of the day.

Top module: `tod_bcd_counter`

## Requirements
- R1: While `rst` is high, at the next clock edge the time becomes 00:00:00 and `day_end` drops to 0.
- R2: A cycle with `sec_tick` high adds one second. A cycle with neither `sec_tick` nor `wr_en` leaves `tod_out` unchanged.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00, so 23:59:59 plus one tick gives 00:00:00.
- R4: The field layout is seconds in bits 7:0, minutes in bits 15:8 and hours in bits 21:16, each as a high BCD digit above a low digit in bits 3:0. A seconds write (lane bit 0) or a minutes write (lane bit 1) lands only when `wr_en` is high, its lane bit is set, the low digit is 9 or less and the high digit is 5 or less.
- R5: An hours write (lane bit 2) lands only when `wr_en` is high, lane bit 2 is set, the low digit is 9 or less and the 6-bit field is 0x23 or less.
- R6: Each field is judged on its own. A field that is not selected, or that fails its check, keeps the value it would have had without the write, while the other fields of the same write still land.
- R7: When a write and `sec_tick` fall in the same cycle, every field that passes its check takes the written value. Every other field takes the value that the tick gives when applied to the time before the write, carries included.
- R8: `day_end` is high exactly when `tod_out` reads 23:59:59.
- R9: A tick or write sampled at one rising edge shows on `tod_out` and `day_end` right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| wr_en | input | 1 | Registered write strobe |
| wr_lane | input | 3 | Field select: bit 0 seconds, bit 1 minutes, bit 2 hours |
| wr_time | input | 22 | Registered write data in the time-word layout |
| tod_out | output | 22 | Current time, packed BCD |
| day_end | output | 1 | High during 23:59:59 |

## Verification
The block has no free parameters: the field widths and wrap limits come from the time format and live in the package. The bench therefore builds the single default configuration. In that configuration, a few directed writes place the counter right before each carry and right before midnight, so every wrap point can be reached in a handful of ticks. Random writes with digits biased to cross 9 and 5 and 0x23 then exercise each accept or reject boundary, in every mix of lanes and with and without a coincident tick.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int MS_W      = 8;
    localparam int HR_W      = 6;
    localparam int NUM_LANES = 3;
    localparam int TOD_W     = HR_W + 2 * MS_W;

    localparam logic [MS_W-1:0] SEC_LIMIT = 8'h59;
    localparam logic [MS_W-1:0] MIN_LIMIT = 8'h59;
    localparam logic [HR_W-1:0] HR_LIMIT  = 6'h23;

    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [MS_W-1:0] min;
        logic [MS_W-1:0] sec;
    } tod_t;

    localparam tod_t LAST_SECOND = '{hr: HR_LIMIT, min: MIN_LIMIT, sec: SEC_LIMIT};

    typedef struct packed {
        tod_t now;
        logic day_end;
    } tod_state_t;

endpackage

// File: rtl/tod_bcd_field.sv
module tod_bcd_field #(
    parameter int             FW    = 8,
    parameter logic [FW-1:0]  LIMIT = 8'h59
) (
    input  logic [FW-1:0] cur_i,
    input  logic          inc_i,
    input  logic [FW-1:0] wr_val_i,
    input  logic          wr_sel_i,
    output logic [FW-1:0] nxt_o,
    output logic          carry_o,
    output logic          wr_ok_o
);
    localparam int HW = FW - 4;

    logic [3:0]    lo;
    logic [HW-1:0] hi;
    logic [HW-1:0] hi_inc;

    always_comb begin
        lo      = cur_i[3:0];
        hi      = cur_i[FW-1:4];
        hi_inc  = hi + HW'(1);
        carry_o = inc_i && (cur_i == LIMIT);
        nxt_o   = cur_i;
        if (inc_i) begin
            if (cur_i == LIMIT) begin
                nxt_o = '0;
            end else if (lo == 4'd9) begin
                nxt_o = {hi_inc, 4'h0};
            end else begin
                nxt_o = {hi, lo + 4'd1};
            end
        end
        wr_ok_o = wr_sel_i && (wr_val_i[3:0] <= 4'd9) && (wr_val_i <= LIMIT);
    end
endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
    import tod_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_tick,
    input  logic                 wr_en,
    input  logic [NUM_LANES-1:0] wr_lane,
    input  logic [TOD_W-1:0]     wr_time,
    output logic [TOD_W-1:0]     tod_out,
    output logic                 day_end
);
    tod_state_t st_d, st_q;
    tod_t       cur, wr;

    logic [MS_W-1:0] sec_nxt, min_nxt;
    logic [HR_W-1:0] hr_nxt;
    logic            sec_carry, min_carry, hr_carry_unused;
    logic [NUM_LANES-1:0] lane_ok;

    assign cur = st_q.now;
    assign wr  = tod_t'(wr_time);

    tod_bcd_field #(.FW(MS_W), .LIMIT(SEC_LIMIT)) u_sec (
        .cur_i(cur.sec), .inc_i(sec_tick),
        .wr_val_i(wr.sec), .wr_sel_i(wr_en && wr_lane[0]),
        .nxt_o(sec_nxt), .carry_o(sec_carry), .wr_ok_o(lane_ok[0])
    );

    tod_bcd_field #(.FW(MS_W), .LIMIT(MIN_LIMIT)) u_min (
        .cur_i(cur.min), .inc_i(sec_carry),
        .wr_val_i(wr.min), .wr_sel_i(wr_en && wr_lane[1]),
        .nxt_o(min_nxt), .carry_o(min_carry), .wr_ok_o(lane_ok[1])
    );

    tod_bcd_field #(.FW(HR_W), .LIMIT(HR_LIMIT)) u_hr (
        .cur_i(cur.hr), .inc_i(min_carry),
        .wr_val_i(wr.hr), .wr_sel_i(wr_en && wr_lane[2]),
        .nxt_o(hr_nxt), .carry_o(hr_carry_unused), .wr_ok_o(lane_ok[2])
    );

    always_comb begin
        st_d             = st_q;
        st_d.now.sec     = lane_ok[0] ? wr.sec : sec_nxt;
        st_d.now.min     = lane_ok[1] ? wr.min : min_nxt;
        st_d.now.hr      = lane_ok[2] ? wr.hr  : hr_nxt;
        st_d.day_end     = (st_d.now == LAST_SECOND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tod_out = st_q.now;
    assign day_end = st_q.day_end;
endmodule

// File: rtl/tod_bcd_counter_checker.sv
module tod_bcd_counter_checker (
    input logic        clk,
    input logic        rst,
    input logic        sec_tick,
    input logic        wr_en,
    input logic [2:0]  wr_lane,
    input logic [21:0] wr_time,
    input logic [21:0] tod_out,
    input logic        day_end
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            assert_reset_clear_R1: assert (tod_out == 22'h0 && !day_end)
                else $error("R1 time not cleared by reset");
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!sec_tick && !wr_en) |=> $stable(tod_out));

    assert_legal_digits_R3: assert property (@(posedge clk) disable iff (rst)
        (tod_out[3:0] <= 4'd9 && tod_out[7:0] <= 8'h59 &&
         tod_out[11:8] <= 4'd9 && tod_out[15:8] <= 8'h59 &&
         tod_out[19:16] <= 4'd9 && tod_out[21:16] <= 6'h23));

    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && !wr_en && tod_out == 22'h235959) |=> (tod_out == 22'h0));

    assert_bad_sec_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sec_tick && wr_lane == 3'b001 && wr_time[3:0] > 4'd9)
        |=> $stable(tod_out));

    assert_bad_hr_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sec_tick && wr_lane == 3'b100 && wr_time[21:16] > 6'h23)
        |=> $stable(tod_out));

    assert_day_end_R8: assert property (@(posedge clk) disable iff (rst)
        day_end == (tod_out == 22'h235959));
endmodule

bind tod_bcd_counter tod_bcd_counter_checker u_chk (.*);

// File: tb/tod_bcd_counter_bench.sv
module tod_bcd_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DAY        = 86400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_lane = 3'b000;
    logic [21:0] wr_time = '0;
    logic [21:0] tod_out;
    logic        day_end;

    int n_chk  = 0;
    int n_fail = 0;
    int model  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_bcd_counter u_tod_bcd_counter (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .wr_en(wr_en),
        .wr_lane(wr_lane), .wr_time(wr_time),
        .tod_out(tod_out), .day_end(day_end)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [21:0] pack_time(input int s);
        logic [7:0] h;
        h = to_bcd(s / 3600);
        return {h[5:0], to_bcd((s / 60) % 60), to_bcd(s % 60)};
    endfunction

    // R4: low digit <= 9, high digit <= 5
    function automatic bit ok_ms(input logic [7:0] b);
        return (b[3:0] <= 4'd9) && (b[7:4] <= 4'd5);
    endfunction

    // R5: low digit <= 9, 6-bit field <= 0x23
    function automatic bit ok_hr(input logic [5:0] b);
        return (b[3:0] <= 4'd9) && (b <= 6'h23);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit tick, input bit we, input logic [2:0] lane,
                        input logic [21:0] data, input string tag);
        int adv, h, m, s;
        @(negedge clk);
        sec_tick = tick;
        wr_en    = we;
        wr_lane  = lane;
        wr_time  = data;
        adv = tick ? (model + 1) % DAY : model;
        h = adv / 3600;
        m = (adv / 60) % 60;
        s = adv % 60;
        if (we && lane[0] && ok_ms(data[7:0]))   s = from_bcd(data[7:0]);
        if (we && lane[1] && ok_ms(data[15:8]))  m = from_bcd(data[15:8]);
        if (we && lane[2] && ok_hr(data[21:16])) h = from_bcd({2'b00, data[21:16]});
        model = h * 3600 + m * 60 + s;
        @(posedge clk);
        #1;
        check({tag, " time"}, {10'h0, tod_out}, {10'h0, pack_time(model)});
        check({tag, " day_end R8"}, {31'h0, day_end}, {31'h0, (model == DAY - 1)});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sec_tick = 1'b0;
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        model = 0;
        check("R1 reset time", {10'h0, tod_out}, 32'h0);
        check("R1 reset day_end", {31'h0, day_end}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        do_reset();

        step(1'b1, 1'b0, 3'b000, '0, "R2 first tick R9");
        step(1'b0, 1'b0, 3'b000, '0, "R2 idle hold");
        step(1'b0, 1'b0, 3'b111, 22'h123456, "R2 lanes without wr_en");

        step(1'b0, 1'b1, 3'b111, 22'h000059, "R4 load 00:00:59");
        step(1'b1, 1'b0, 3'b000, '0, "R3 seconds carry");
        step(1'b0, 1'b1, 3'b111, 22'h005959, "R4 load 00:59:59");
        step(1'b1, 1'b0, 3'b000, '0, "R3 minutes carry");
        step(1'b0, 1'b1, 3'b111, 22'h235958, "R5 load 23:59:58");
        step(1'b1, 1'b0, 3'b000, '0, "R8 last second");
        step(1'b1, 1'b0, 3'b000, '0, "R3 day wrap");
        check("R3 midnight", {10'h0, tod_out}, 32'h0);

        step(1'b0, 1'b1, 3'b001, 22'h00005A, "R4 reject sec 5A");
        step(1'b0, 1'b1, 3'b001, 22'h000060, "R4 reject sec 60");
        step(1'b0, 1'b1, 3'b001, 22'h000059, "R4 accept sec 59");
        step(1'b0, 1'b1, 3'b010, 22'h007000, "R4 reject min 70");
        step(1'b0, 1'b1, 3'b001, 22'h001210, "R6 minutes lane clear");
        step(1'b0, 1'b1, 3'b100, 22'h240000, "R5 reject hr 24");
        step(1'b0, 1'b1, 3'b100, 22'h1A0000, "R5 reject hr 1A");
        step(1'b0, 1'b1, 3'b100, 22'h230000, "R5 accept hr 23");
        step(1'b0, 1'b1, 3'b111, 22'h24300A, "R6 only minutes land");

        step(1'b0, 1'b1, 3'b111, 22'h102059, "R4 load 10:20:59");
        step(1'b1, 1'b1, 3'b001, 22'h000030, "R7 tick with sec write");
        step(1'b0, 1'b1, 3'b111, 22'h105959, "R4 load 10:59:59");
        step(1'b1, 1'b1, 3'b100, 22'h050000, "R7 tick with hr write");
        step(1'b1, 1'b1, 3'b001, 22'h0000AA, "R7 tick with bad sec write");

        for (int i = 0; i < 4000; i++) begin
            bit          t, w;
            logic [2:0]  ln;
            logic [21:0] d;
            t  = ($urandom % 2) == 0;
            w  = ($urandom % 6) == 0;
            ln = 3'($urandom);
            d  = {2'($urandom % 4), 4'($urandom % 12),
                  4'($urandom % 8), 4'($urandom % 12),
                  4'($urandom % 8), 4'($urandom % 12)};
            if (($urandom % 50) == 0) d = 22'h235958;
            step(t, w, ln, d, "R2 R3 R4 R5 R6 R7 random");
        end

        do_reset();
        step(1'b1, 1'b0, 3'b000, '0, "R1 tick after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule